// File: doc/BRIEF.md
# ADC channel scan sequencer

The sequencer drives an external analog-to-digital converter through a repeating scan. Software fills a 32-entry selector table. Each 8-bit entry holds a 3-bit bias-switch pattern in bits 7:5 and a 5-bit channel code in bits 4:0. Software then sets the enable and start control bits. The sequencer walks the table from entry 0. For each entry it drives the channel select and bias outputs and issues a one-cycle conversion request. It waits for the converter's done pulse and stores the 10-bit sample, with the converter's gain flag above it, in result slot i for table entry i.

A pass ends in one of two ways: at an entry whose channel code is 0x1F, or after entry 31. At the end of a pass the sequencer sets a sticky round-complete flag and raises an interrupt that passes two mask levels. It then sleeps for one of eight programmable durations, counted in millisecond ticks prescaled from the clock. After the sleep it scans again from entry 0 and overwrites the previous results. Channels 22, 24, 25 and 26 are skipped unless software grants each one separately.

Software reaches everything through a write port and a combinational read port on a 7-bit address:

| Address | Contents |
|---|---|
| 0x00–0x1F | Selector table |
| 0x20–0x3F | Result file (read only) |
| 0x40 | Control: bit 0 enable, bit 1 start, bits 4:2 sleep select |
| 0x41 | Round-complete flag, bit 0, write 1 to clear |
| 0x42 | Flag mask, bit 0 |
| 0x43 | Summary status, bit 1 |
| 0x44 | Summary mask, bit 1 |
| 0x45 | Channel grants: bit 0 ch22, bit 1 ch24, bit 2 ch25, bit 3 ch26 |

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the following all read as zero: control, flag, table and result registers, `conv_start`, `conv_bias` and `irq_out`.
- R2: No conversion request is issued unless control bit 0 (enable) and bit 1 (start) are both 1.
- R3: Table entries are visited in index order. With each request, `conv_chan` equals entry bits 4:0 and `conv_bias` equals entry bits 7:5, and both hold until the conversion completes.
- R4: On `conv_done`, result slot i (read at 0x20+i) receives {`conv_gain`, `conv_data`} for table entry i.
- R5: An entry with channel code 0x1F ends the pass without a conversion. Later entries are not visited and their result slots are unchanged.
- R6: An entry selecting channel 22, 24, 25 or 26 is skipped unless its grant bit at 0x45 is 1 (bit 0 ch22, bit 1 ch24, bit 2 ch25, bit 3 ch26). The result slot of a skipped entry is unchanged.
- R7: The end of a pass sets the flag at 0x41 bit 0. Writing 1 to that bit clears the flag, and writing 0 leaves it set.
- R8: Summary bit 1 at 0x43 equals flag AND NOT (0x42 bit 0). `irq_out` equals that summary bit AND NOT (0x44 bit 1).
- R9: Sleep select S in control bits 4:2 picks a duration D from the sleep table. The next pass's first request rises D*CLK_PER_MS+2 cycles after the flag rises, and that pass restarts at entry 0.
- R10: Each pass overwrites the result slots written by the previous pass.
- R11: Clearing enable aborts the scan. No further request is issued, `conv_bias` returns to 0, and a later restart begins at entry 0.
- R12: A table with no 0x1F code ends its pass after entry 31 has been converted.
- R13: Writes to the result file addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | DATA_W+1 | Read data, combinational |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 5 | Analog channel select |
| conv_bias | output | 3 | Bias-switch controls |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | DATA_W | Converted sample |
| conv_gain | input | 1 | Gain setting used for the sample |
| irq_out | output | 1 | Round-complete interrupt, active high |

## Verification
The bench builds the block with DATA_W = 10 and CLK_PER_MS = 4 and keeps the default sleep table of 0 to 27 ticks. The longest sleep is therefore about a hundred cycles. This lets the exact sleep-to-restart distance be measured for several sleep selects, and lets back-to-back passes, overwrite of earlier results and a full 32-entry pass without a terminator all run inside a short run.

// File: rtl/adc_scan_pkg.sv
// Shared constants, state type and the reserved-channel rule for the scan
// sequencer. Assumes a 5-bit channel code and a 32-entry table.
package adc_scan_pkg;
    localparam int ENTRIES = 32;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int CODE_W  = 5;
    localparam int BIAS_W  = 3;
    localparam int ENTRY_W = CODE_W + BIAS_W;
    localparam int ADDR_W  = 7;
    localparam int SEL_W   = 3;
    localparam int RSV_W   = 4;

    localparam logic [CODE_W-1:0] CODE_STOP = 5'h1F;

    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h40;
    localparam logic [ADDR_W-1:0] A_FLAG  = 7'h41;
    localparam logic [ADDR_W-1:0] A_FMASK = 7'h42;
    localparam logic [ADDR_W-1:0] A_TOP   = 7'h43;
    localparam logic [ADDR_W-1:0] A_TMASK = 7'h44;
    localparam logic [ADDR_W-1:0] A_GRANT = 7'h45;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEL,
        ST_CONV,
        ST_SLEEP
    } seq_state_t;

    // True when a channel code is reserved and its grant bit is clear.
    function automatic logic chan_blocked(input logic [CODE_W-1:0] code,
                                          input logic [RSV_W-1:0]  grant);
        case (code)
            5'd22:   return !grant[0];
            5'd24:   return !grant[1];
            5'd25:   return !grant[2];
            5'd26:   return !grant[3];
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/adc_scan_regs.sv
// Register bank of the scan sequencer. Holds the selector table, the control
// bits, the round-complete flag with its masks, and the channel grants.
// Computes the interrupt output. Assumes single-cycle writes and a
// combinational read path.
module adc_scan_regs
    import adc_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [IDX_W-1:0]    seq_idx,
    input  logic                pass_end,
    output logic [ENTRY_W-1:0]  tab_entry,
    output logic [7:0]          reg_rdata,
    output logic                ctrl_en,
    output logic                ctrl_start,
    output logic [SEL_W-1:0]    sleep_sel,
    output logic [RSV_W-1:0]    rsv_en,
    output logic                rnd_flag,
    output logic                irq_out
);
    logic [ENTRY_W-1:0] tab_q [ENTRIES];
    logic [SEL_W+1:0]   ctrl_q;
    logic               fmask_q;
    logic               tmask_q;
    logic [RSV_W-1:0]   grant_q;
    logic               top_bit;
    logic               tab_wr;

    assign tab_wr = wr_en && (wr_addr[ADDR_W-1:IDX_W] == '0);

    // Selector table storage, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tab_q[i] <= '0;
        end else if (tab_wr) begin
            tab_q[wr_addr[IDX_W-1:0]] <= wr_data[ENTRY_W-1:0];
        end
    end

    // Control, mask and grant registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            fmask_q <= 1'b0;
            tmask_q <= 1'b0;
            grant_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:  ctrl_q  <= wr_data[SEL_W+1:0];
                A_FMASK: fmask_q <= wr_data[0];
                A_TMASK: tmask_q <= wr_data[1];
                A_GRANT: grant_q <= wr_data[RSV_W-1:0];
                default: ;
            endcase
        end
    end

    // Sticky round-complete flag; a set at pass end wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rnd_flag <= 1'b0;
        else if (pass_end)
            rnd_flag <= 1'b1;
        else if (wr_en && wr_addr == A_FLAG && wr_data[0])
            rnd_flag <= 1'b0;
    end

    assign tab_entry  = tab_q[seq_idx];
    assign ctrl_en    = ctrl_q[0];
    assign ctrl_start = ctrl_q[1];
    assign sleep_sel  = ctrl_q[SEL_W+1:2];
    assign rsv_en     = grant_q;
    assign top_bit    = rnd_flag & ~fmask_q;
    assign irq_out    = top_bit & ~tmask_q;

    // Read multiplexer for table and control addresses.
    always_comb begin
        reg_rdata = '0;
        if (rd_addr[ADDR_W-1:IDX_W] == '0) begin
            reg_rdata[ENTRY_W-1:0] = tab_q[rd_addr[IDX_W-1:0]];
        end else begin
            case (rd_addr)
                A_CTRL:  reg_rdata[SEL_W+1:0] = ctrl_q;
                A_FLAG:  reg_rdata[0] = rnd_flag;
                A_FMASK: reg_rdata[0] = fmask_q;
                A_TOP:   reg_rdata[1] = top_bit;
                A_TMASK: reg_rdata[1] = tmask_q;
                A_GRANT: reg_rdata[RSV_W-1:0] = grant_q;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/adc_scan_results.sv
// Result file: one slot per table entry, each holding the gain flag above
// the sample. Assumes at most one write per cycle.
module adc_scan_results
    import adc_scan_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W:0]    wr_val,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DATA_W:0]    rd_val
);
    logic [DATA_W:0] slot_q [ENTRIES];

    // Store a finished conversion into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) slot_q[i] <= '0;
        end else if (we) begin
            slot_q[wr_idx] <= wr_val;
        end
    end

    assign rd_val = slot_q[rd_idx];
endmodule

// File: rtl/adc_scan_sleep.sv
// Inter-pass sleep timer. On load it takes a duration from an 8-entry table
// of millisecond counts. While run is high it decrements once per
// prescaled tick. It reports expiry when the count is zero.
module adc_scan_sleep
    import adc_scan_pkg::*;
#(
    parameter int CLK_PER_MS = 250000,
    parameter int CNT_W      = 5,
    parameter logic [(1<<SEL_W)*CNT_W-1:0] SLEEP_MS =
        {5'd27, 5'd20, 5'd12, 5'd8, 5'd4, 5'd2, 5'd1, 5'd0}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    input  logic             run,
    output logic             expired
);
    localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PW-1:0] PRESC_LAST = PW'(CLK_PER_MS - 1);

    logic [PW-1:0]    presc_q;
    logic [CNT_W-1:0] cnt_q;

    // Load the duration, then count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            presc_q <= '0;
            cnt_q   <= SLEEP_MS[sel*CNT_W +: CNT_W];
        end else if (run && cnt_q != '0) begin
            if (presc_q == PRESC_LAST) begin
                presc_q <= '0;
                cnt_q   <= cnt_q - 1'b1;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_scan_fsm.sv
// Scan control: walks the table, skips reserved channels that have no
// grant, issues the conversion request, commits results, ends the pass
// and hands over to the sleep timer. Assumes conv_done arrives at least
// one cycle after conv_start.
module adc_scan_fsm
    import adc_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_en,
    input  logic               ctrl_start,
    input  logic [ENTRY_W-1:0] tab_entry,
    input  logic [RSV_W-1:0]   rsv_en,
    input  logic               conv_done,
    input  logic               slp_expired,
    output logic [IDX_W-1:0]   idx,
    output logic               conv_start,
    output logic [CODE_W-1:0]  conv_chan,
    output logic [BIAS_W-1:0]  conv_bias,
    output logic               res_we,
    output logic               pass_end,
    output logic               slp_load,
    output logic               slp_run
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ENTRIES - 1);

    seq_state_t         state_q, state_d;
    logic [IDX_W-1:0]   idx_d;
    logic               go_conv;
    logic [ENTRY_W-1:0] sel_q;
    logic [CODE_W-1:0]  code;
    logic               last;

    assign code = tab_entry[CODE_W-1:0];
    assign last = (idx == IDX_LAST);

    // Next-state decision for the scan.
    always_comb begin
        state_d  = state_q;
        idx_d    = idx;
        go_conv  = 1'b0;
        res_we   = 1'b0;
        pass_end = 1'b0;
        if (!ctrl_en) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (ctrl_start) begin
                    state_d = ST_SEL;
                    idx_d   = '0;
                end
                ST_SEL: begin
                    if (code == CODE_STOP) begin
                        pass_end = 1'b1;
                        state_d  = ST_SLEEP;
                    end else if (chan_blocked(code, rsv_en)) begin
                        if (last) begin
                            pass_end = 1'b1;
                            state_d  = ST_SLEEP;
                        end else begin
                            idx_d = idx + 1'b1;
                        end
                    end else begin
                        go_conv = 1'b1;
                        state_d = ST_CONV;
                    end
                end
                ST_CONV: if (conv_done) begin
                    res_we = 1'b1;
                    if (last) begin
                        pass_end = 1'b1;
                        state_d  = ST_SLEEP;
                    end else begin
                        idx_d   = idx + 1'b1;
                        state_d = ST_SEL;
                    end
                end
                ST_SLEEP: if (slp_expired) begin
                    idx_d   = '0;
                    state_d = ctrl_start ? ST_SEL : ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State, index, request pulse and latched selector entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx        <= '0;
            conv_start <= 1'b0;
            sel_q      <= '0;
        end else begin
            state_q    <= state_d;
            idx        <= idx_d;
            conv_start <= go_conv;
            if (go_conv)
                sel_q <= tab_entry;
            else if (state_d == ST_IDLE)
                sel_q <= '0;
        end
    end

    assign conv_chan = sel_q[CODE_W-1:0];
    assign conv_bias = sel_q[ENTRY_W-1:CODE_W];
    assign slp_load  = pass_end;
    assign slp_run   = (state_q == ST_SLEEP);
endmodule

// File: rtl/adc_scan_seq.sv
// Top of the scan sequencer: register bank, scan control, sleep timer and
// result file, plus the read-data multiplexer. Assumes an external
// converter that answers each conv_start with one conv_done pulse.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int DATA_W     = 10,
    parameter int CLK_PER_MS = 250000,
    parameter int SLP_W      = 5,
    parameter logic [(1<<SEL_W)*SLP_W-1:0] SLEEP_MS =
        {5'd27, 5'd20, 5'd12, 5'd8, 5'd4, 5'd2, 5'd1, 5'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [6:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [6:0]        rd_addr,
    output logic [DATA_W:0]   rd_data,
    output logic              conv_start,
    output logic [4:0]        conv_chan,
    output logic [2:0]        conv_bias,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              conv_gain,
    output logic              irq_out
);
    logic [ENTRY_W-1:0] tab_entry;
    logic [7:0]         reg_rdata;
    logic               ctrl_en;
    logic               ctrl_start;
    logic [SEL_W-1:0]   sleep_sel;
    logic [RSV_W-1:0]   rsv_en;
    logic               rnd_flag;
    logic [IDX_W-1:0]   idx;
    logic               res_we;
    logic               pass_end;
    logic               slp_load;
    logic               slp_run;
    logic               slp_expired;
    logic [DATA_W:0]    res_rd;
    logic               rd_is_res;

    adc_scan_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .seq_idx(idx),
        .pass_end(pass_end), .tab_entry(tab_entry), .reg_rdata(reg_rdata),
        .ctrl_en(ctrl_en), .ctrl_start(ctrl_start), .sleep_sel(sleep_sel),
        .rsv_en(rsv_en), .rnd_flag(rnd_flag), .irq_out(irq_out)
    );

    adc_scan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .ctrl_start(ctrl_start),
        .tab_entry(tab_entry), .rsv_en(rsv_en), .conv_done(conv_done),
        .slp_expired(slp_expired), .idx(idx), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_bias(conv_bias), .res_we(res_we),
        .pass_end(pass_end), .slp_load(slp_load), .slp_run(slp_run)
    );

    adc_scan_sleep #(
        .CLK_PER_MS(CLK_PER_MS), .CNT_W(SLP_W), .SLEEP_MS(SLEEP_MS)
    ) u_sleep (
        .clk(clk), .rst_n(rst_n), .load(slp_load), .sel(sleep_sel),
        .run(slp_run), .expired(slp_expired)
    );

    adc_scan_results #(.DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .we(res_we), .wr_idx(idx),
        .wr_val({conv_gain, conv_data}), .rd_idx(rd_addr[IDX_W-1:0]),
        .rd_val(res_rd)
    );

    assign rd_is_res = (rd_addr[6:5] == 2'b01);
    assign rd_data   = rd_is_res ? res_rd : {{(DATA_W-7){1'b0}}, reg_rdata};
endmodule

// File: rtl/adc_scan_seq_chk.sv
// Checker for the scan sequencer, attached to the top by bind. It watches
// the conversion handshake, the enable bit, the pass-end event and the flag.
module adc_scan_seq_chk
    import adc_scan_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start,
    input logic [CODE_W-1:0] conv_chan,
    input logic [RSV_W-1:0] rsv_en,
    input logic             ctrl_en,
    input logic             pass_end,
    input logic             rnd_flag
);
    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(ctrl_en));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r3_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start && ctrl_en |=> $stable(conv_chan));

    a_r5_no_stop_conv: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_chan != CODE_STOP);

    a_r6_grant_needed: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !chan_blocked(conv_chan, $past(rsv_en)));

    a_r7_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pass_end |=> rnd_flag);

    a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !conv_start);
endmodule

bind adc_scan_seq adc_scan_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
    .rsv_en(rsv_en), .ctrl_en(ctrl_en), .pass_end(pass_end),
    .rnd_flag(rnd_flag)
);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
// Directed bench for the scan sequencer: a converter model answers each
// request, and one task per scenario checks its own results.
module test_adc_scan_seq;
    localparam int DW  = 10;
    localparam int CPM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [6:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [6:0]    rd_addr = '0;
    logic [DW:0]   rd_data;
    logic          conv_start;
    logic [4:0]    conv_chan;
    logic [2:0]    conv_bias;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          conv_gain = 1'b0;
    logic          irq_out;

    int errors = 0;
    int checks = 0;
    int log_n = 0;
    int pass_id = 0;
    logic [4:0] log_chan [0:255];
    logic [2:0] log_bias [0:255];

    always #2 clk = ~clk;

    adc_scan_seq #(.DATA_W(DW), .CLK_PER_MS(CPM)) i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_bias(conv_bias),
        .conv_done(conv_done), .conv_data(conv_data), .conv_gain(conv_gain),
        .irq_out(irq_out)
    );

    function automatic logic [DW:0] model(input logic [4:0] ch, input int pid);
        logic [DW-1:0] d;
        d = DW'((int'(ch) * 37 + pid * 5) & 1023);
        return {ch[0] ^ 1'(pid & 1), d};
    endfunction

    function automatic int sleep_ms(input int sel);
        case (sel)
            0: return 0;  1: return 1;  2: return 2;  3: return 4;
            4: return 8;  5: return 12; 6: return 20; default: return 27;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [DW:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (irq_out !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(irq_out === 1'b1, req, int'(irq_out), 1);
    endtask

    // Converter model: three-cycle latency, data derived from channel and pass.
    initial begin
        logic [4:0] ch;
        forever begin
            @(negedge clk);
            if (conv_start === 1'b1) begin
                ch = conv_chan;
                log_chan[log_n[7:0]] = conv_chan;
                log_bias[log_n[7:0]] = conv_bias;
                log_n++;
                repeat (3) @(negedge clk);
                {conv_gain, conv_data} = model(ch, pass_id);
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    task automatic load_basic_table();
        for (int i = 0; i < 5; i++) wr(7'(i), {3'(i), 5'(i * 5 + 1)});
        wr(7'd5, 8'hFF);
        wr(7'd6, 8'h02);
    endtask

    task automatic t_reset();
        logic [DW:0] v;
        rd(7'h40, v); chk(v == 0, "R1 ctrl", int'(v), 0);
        rd(7'h41, v); chk(v == 0, "R1 flag", int'(v), 0);
        rd(7'h00, v); chk(v == 0, "R1 table", int'(v), 0);
        rd(7'h20, v); chk(v == 0, "R1 result", int'(v), 0);
        chk(irq_out === 1'b0 && conv_start === 1'b0 && conv_bias === 3'd0,
            "R1 outputs", int'({irq_out, conv_start, conv_bias}), 0);
    endtask

    task automatic t_gate();
        int base;
        wr(7'h00, 8'h03);
        base = log_n;
        wr(7'h40, 8'h01);
        repeat (40) @(negedge clk);
        chk(log_n == base, "R2 enable only", log_n - base, 0);
        wr(7'h40, 8'h02);
        repeat (40) @(negedge clk);
        chk(log_n == base, "R2 start only", log_n - base, 0);
        wr(7'h40, 8'h00);
    endtask

    task automatic t_basic();
        int base;
        logic [DW:0] v;
        load_basic_table();
        pass_id = 1;
        base = log_n;
        wr(7'h40, 8'h1F);
        wait_irq("R7 pass end");
        wr(7'h40, 8'h00);
        chk(log_n - base == 5, "R5 stop code", log_n - base, 5);
        for (int i = 0; i < 5; i++) begin
            chk(log_chan[base + i] == 5'(i * 5 + 1), "R3 channel order",
                int'(log_chan[base + i]), i * 5 + 1);
            chk(log_bias[base + i] == 3'(i), "R3 bias", int'(log_bias[base + i]), i);
            rd(7'(32 + i), v);
            chk(v == model(5'(i * 5 + 1), 1), "R4 result", int'(v),
                int'(model(5'(i * 5 + 1), 1)));
        end
        rd(7'(32 + 5), v); chk(v == 0, "R5 stop slot", int'(v), 0);
        rd(7'(32 + 6), v); chk(v == 0, "R5 after stop", int'(v), 0);
        rd(7'h41, v); chk(v == 1, "R7 flag", int'(v), 1);
        rd(7'h43, v); chk(v == 2, "R8 summary", int'(v), 2);
    endtask

    task automatic t_irq_mask();
        logic [DW:0] v;
        wr(7'h42, 8'h01);
        rd(7'h43, v); chk(v == 0, "R8 flag mask summary", int'(v), 0);
        chk(irq_out === 1'b0, "R8 flag mask irq", int'(irq_out), 0);
        rd(7'h41, v); chk(v == 1, "R8 flag kept", int'(v), 1);
        wr(7'h42, 8'h00);
        wr(7'h44, 8'h02);
        rd(7'h43, v); chk(v == 2, "R8 top mask summary", int'(v), 2);
        chk(irq_out === 1'b0, "R8 top mask irq", int'(irq_out), 0);
        wr(7'h44, 8'h00);
        chk(irq_out === 1'b1, "R8 unmasked irq", int'(irq_out), 1);
        wr(7'h41, 8'h00);
        rd(7'h41, v); chk(v == 1, "R7 write zero keeps", int'(v), 1);
        wr(7'h41, 8'h01);
        rd(7'h41, v); chk(v == 0, "R7 write one clears", int'(v), 0);
        chk(irq_out === 1'b0, "R7 irq cleared", int'(irq_out), 0);
    endtask

    task automatic t_sleep(input int sel);
        int base, n, exp_gap;
        logic [DW:0] v;
        load_basic_table();
        wr(7'h41, 8'h01);
        pass_id = 10 + 2 * sel;
        base = log_n;
        wr(7'h40, 8'(sel << 2) | 8'h03);
        wait_irq("R9 first pass");
        pass_id = 11 + 2 * sel;
        n = 0;
        while (conv_start !== 1'b1 && n < 500) begin
            @(negedge clk);
            n++;
        end
        exp_gap = sleep_ms(sel) * CPM + 2;
        chk(n == exp_gap, "R9 sleep length", n, exp_gap);
        wr(7'h41, 8'h01);
        wait_irq("R9 second pass");
        wr(7'h40, 8'h00);
        chk(log_chan[base + 5] == 5'd1, "R9 restart entry 0", int'(log_chan[base + 5]), 1);
        for (int i = 0; i < 5; i++) begin
            rd(7'(32 + i), v);
            chk(v == model(5'(i * 5 + 1), pass_id), "R10 overwrite", int'(v),
                int'(model(5'(i * 5 + 1), pass_id)));
        end
    endtask

    task automatic t_rsv();
        int base;
        logic [DW:0] v;
        logic [DW:0] saved [0:4];
        for (int i = 0; i < 5; i++) rd(7'(32 + i), saved[i]);
        wr(7'd0, {3'd5, 5'd22});
        wr(7'd1, {3'd5, 5'd23});
        wr(7'd2, {3'd5, 5'd24});
        wr(7'd3, {3'd5, 5'd25});
        wr(7'd4, {3'd5, 5'd26});
        wr(7'd5, 8'h1F);
        wr(7'h45, 8'h00);
        wr(7'h41, 8'h01);
        pass_id = 30;
        base = log_n;
        wr(7'h40, 8'h1F);
        wait_irq("R6 pass");
        wr(7'h40, 8'h00);
        chk(log_n - base == 1, "R6 only free channel", log_n - base, 1);
        chk(log_chan[base] == 5'd23, "R6 channel", int'(log_chan[base]), 23);
        rd(7'd33, v);
        chk(v == model(5'd23, 30), "R6 free slot", int'(v), int'(model(5'd23, 30)));
        for (int i = 0; i < 5; i++) begin
            if (i != 1) begin
                rd(7'(32 + i), v);
                chk(v == saved[i], "R6 skipped slot unchanged", int'(v), int'(saved[i]));
            end
        end
        wr(7'h45, 8'h05);
        wr(7'h41, 8'h01);
        pass_id = 31;
        base = log_n;
        wr(7'h40, 8'h1F);
        wait_irq("R6 granted pass");
        wr(7'h40, 8'h00);
        chk(log_n - base == 3, "R6 granted count", log_n - base, 3);
        chk(log_chan[base] == 5'd22 && log_chan[base + 1] == 5'd23 &&
            log_chan[base + 2] == 5'd25, "R6 granted order",
            int'(log_chan[base + 2]), 25);
        rd(7'd34, v); chk(v == saved[2], "R6 ch24 unchanged", int'(v), int'(saved[2]));
        rd(7'd36, v); chk(v == saved[4], "R6 ch26 unchanged", int'(v), int'(saved[4]));
    endtask

    task automatic t_abort();
        int base, n;
        wr(7'h41, 8'h01);
        base = log_n;
        wr(7'h40, 8'h1F);
        n = 0;
        while (log_n < base + 2 && n < 500) begin
            @(negedge clk);
            n++;
        end
        wr(7'h40, 8'h00);
        repeat (40) @(negedge clk);
        chk(log_n == base + 2, "R11 no request after abort", log_n - base, 2);
        chk(conv_bias == 3'd0, "R11 bias off", int'(conv_bias), 0);
        base = log_n;
        wr(7'h40, 8'h1F);
        n = 0;
        while (log_n == base && n < 500) begin
            @(negedge clk);
            n++;
        end
        wr(7'h40, 8'h00);
        chk(log_chan[base] == 5'd22, "R11 restart entry 0", int'(log_chan[base]), 22);
    endtask

    task automatic t_noterm();
        int base;
        logic [DW:0] v;
        for (int i = 0; i < 32; i++) wr(7'(i), {3'd0, 5'(i % 20)});
        repeat (10) @(negedge clk);
        wr(7'h41, 8'h01);
        pass_id = 40;
        base = log_n;
        wr(7'h40, 8'h1F);
        wait_irq("R12 pass");
        wr(7'h40, 8'h00);
        chk(log_n - base == 32, "R12 full table", log_n - base, 32);
        rd(7'd63, v);
        chk(v == model(5'd11, 40), "R12 last slot", int'(v), int'(model(5'd11, 40)));
    endtask

    task automatic t_wprot();
        logic [DW:0] v0, v1;
        rd(7'h20, v0);
        wr(7'h20, 8'hAA);
        rd(7'h20, v1);
        chk(v1 == v0, "R13 result write ignored", int'(v1), int'(v0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gate();
        t_basic();
        t_irq_mask();
        t_sleep(3);
        t_sleep(0);
        t_sleep(7);
        t_rsv();
        t_abort();
        t_noterm();
        t_wprot();
        repeat (20) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule